// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block sits next to an asynchronous DRAM access controller and keeps the memory alive. It takes care of two jobs. The first is bring-up. After reset it holds both strobes high for a start-up pause. It then runs a fixed number of refresh cycles, each of which contains a RAS pulse. Only after these does it declare the memory ready. The second job is upkeep. A pacing timer lets one refresh fall due per period, and each refresh runs as a CAS-before-RAS cycle. In that kind of cycle the row comes from the memory's own counter, so the block drives no address, write-enable or output-enable.

The access controller and this block share the strobes through a request/grant handshake. The controller raises a request while it wants to open or hold a page. It receives a grant only when the block is ready, no refresh is owed and no refresh cycle is in flight. A refresh that falls due while the controller holds the grant is counted, not dropped. All owed refreshes run back to back once the controller lets go of the grant. The owed count saturates at a small limit, and a one-cycle overflow pulse reports each refresh that is lost. The controller also reports its own RAS activity. If neither side produces any RAS activity for a whole idle limit, the block runs the initialization burst again. This re-run has no pause in front of it.

All lengths are parameters counted in system clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, ras_n_o and cas_n_o are 1, and ready_o, host_gnt_o and ref_ovf_o are 0.
- R2: For the first PAUSE_CYC cycles after reset is released, ras_n_o and cas_n_o stay 1 and ready_o stays 0.
- R3: After the pause, exactly INIT_CYCLES RAS pulses are issued before ready_o first reads 1. No grant is given while ready_o is 0.
- R4: Every RAS pulse is a CAS-before-RAS cycle. cas_n_o is 0 for at least T_CSR cycles before ras_n_o falls. cas_n_o stays 0 for at least T_CHR cycles after ras_n_o falls. ras_n_o stays 0 for at least T_RAS cycles.
- R5: ras_n_o is 1 for at least T_RP cycles between two RAS pulses.
- R6: While ready and never granted, the block issues exactly one refresh per REF_PERIOD cycles. Any window of N·REF_PERIOD cycles therefore holds N RAS falls.
- R7: A request made while ready, with no refresh owed and no refresh cycle in flight, is granted on the next cycle. The grant stays up while the request is held and drops one cycle after the request falls. While the grant is 1, ras_n_o and cas_n_o are 1.
- R8: Refreshes that fall due during a grant are counted, up to OWE_MAX. They are issued back to back after the grant ends.
- R9: ref_ovf_o pulses for one cycle when a refresh falls due while OWE_MAX refreshes are already owed. It stays 0 at all other times.
- R10: If neither this block's RAS nor host_ras_i is active for IDLE_LIMIT consecutive cycles while ready, then ready_o and host_gnt_o drop together. The block then issues INIT_CYCLES RAS pulses with no pause and raises ready_o again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_i | input | 1 | Access controller wants the strobes or holds an open page |
| host_ras_i | input | 1 | Access controller currently drives its RAS active |
| host_gnt_o | output | 1 | Strobes belong to the access controller |
| ready_o | output | 1 | Initialization complete; normal traffic allowed |
| ras_n_o | output | 1 | Refresh RAS strobe, active low |
| cas_n_o | output | 1 | Refresh CAS strobe for both byte lanes, active low |
| ref_ovf_o | output | 1 | One-cycle pulse: a refresh was lost at saturation |

## Verification
Several corner cases are exercised. Refreshes piled up behind a grant of one to six periods must return as exactly min(owed, OWE_MAX) back-to-back cycles plus the next paced one. A counter that lost postponed refreshes would show too few RAS falls, and one that did not saturate would show too many with no overflow pulse. Requests raised during the initialization burst must never be granted, and the burst must be counted exactly. An off-by-one init counter shows up as seven or nine RAS falls before ready. A grant held with no RAS activity must trigger a re-run of initialization after exactly the idle limit, with no pause in front of it. A design that restarted the full power-up pause, or that never re-initialized, would miss the expected time of the first RAS fall.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_ACT,
    SQ_PRE
  } seq_st_t;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_INIT,
    PH_RUN
  } phase_t;

  // Bits needed to count from 0 to n-1 (at least one bit).
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Total cycles one refresh keeps the strobe path busy.
  function automatic int unsigned cbr_cycles(input int unsigned csr, input int unsigned ras,
                                             input int unsigned rp);
    return csr + ras + rp;
  endfunction

endpackage

// File: rtl/dref_strobe_seq.sv
module dref_strobe_seq
  import dref_pkg::*;
#(
  parameter int unsigned T_CSR = 1,
  parameter int unsigned T_CHR = 2,
  parameter int unsigned T_RAS = 5,
  parameter int unsigned T_RP  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic act_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int unsigned CW = cnt_bits(max3(T_CSR, T_RAS, T_RP));
  localparam logic [CW-1:0] CSR_LD  = CW'(T_CSR - 1);
  localparam logic [CW-1:0] RAS_LD  = CW'(T_RAS - 1);
  localparam logic [CW-1:0] RP_LD   = CW'(T_RP - 1);
  localparam logic [CW-1:0] CAS_REL = CW'(T_RAS - T_CHR);

  seq_st_t       st;
  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start_i) begin
          st  <= SQ_SETUP;
          cnt <= CSR_LD;
        end
        SQ_SETUP: if (last) begin
          st  <= SQ_ACT;
          cnt <= RAS_LD;
        end else cnt <= cnt - CW'(1);
        SQ_ACT: if (last) begin
          st  <= SQ_PRE;
          cnt <= RP_LD;
        end else cnt <= cnt - CW'(1);
        SQ_PRE: if (last) st <= SQ_IDLE;
                else cnt <= cnt - CW'(1);
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o  = (st != SQ_IDLE);
  assign done_o  = (st == SQ_PRE) && last;
  assign act_o   = (st == SQ_ACT);
  assign ras_n_o = !act_o;
  assign cas_n_o = !((st == SQ_SETUP) || ((st == SQ_ACT) && (cnt >= CAS_REL)));

endmodule

// File: rtl/dref_pace_timer.sv
module dref_pace_timer
  import dref_pkg::*;
#(
  parameter int unsigned REF_PERIOD = 1560,
  parameter int unsigned OWE_MAX    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic consume_i,
  output logic pending_o,
  output logic sat_o,
  output logic ovf_o
);
  localparam int unsigned PW = cnt_bits(REF_PERIOD);
  localparam int unsigned OW = cnt_bits(OWE_MAX + 1);
  localparam logic [PW-1:0] PER_LAST = PW'(REF_PERIOD - 1);
  localparam logic [OW-1:0] OWE_TOP  = OW'(OWE_MAX);

  logic [PW-1:0] per_cnt;
  logic [OW-1:0] owed;
  logic          tick;

  assign tick = en_i && (per_cnt == PER_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) per_cnt <= '0;
    else if (tick)       per_cnt <= '0;
    else                 per_cnt <= per_cnt + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else begin
      case ({tick, consume_i})
        2'b10:   if (!sat_o) owed <= owed + OW'(1);
        2'b01:   owed <= owed - OW'(1);
        default: owed <= owed;
      endcase
    end
  end

  assign pending_o = (owed != '0);
  assign sat_o     = (owed == OWE_TOP);
  assign ovf_o     = tick && sat_o && !consume_i;

endmodule

// File: rtl/dref_idle_watch.sv
module dref_idle_watch
  import dref_pkg::*;
#(
  parameter int unsigned IDLE_LIMIT = 800000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic act_i,
  output logic expire_o
);
  localparam int unsigned IW = cnt_bits(IDLE_LIMIT);
  localparam logic [IW-1:0] LIM_LAST = IW'(IDLE_LIMIT - 1);

  logic [IW-1:0] quiet;

  assign expire_o = en_i && !act_i && (quiet == LIM_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i || act_i || expire_o) quiet <= '0;
    else                                       quiet <= quiet + IW'(1);
  end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dref_pkg::*;
#(
  parameter int unsigned PAUSE_CYC   = 20000,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned REF_PERIOD  = 1560,
  parameter int unsigned IDLE_LIMIT  = 800000,
  parameter int unsigned OWE_MAX     = 7,
  parameter int unsigned T_CSR       = 1,
  parameter int unsigned T_CHR       = 2,
  parameter int unsigned T_RAS       = 5,
  parameter int unsigned T_RP        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_req_i,
  input  logic host_ras_i,
  output logic host_gnt_o,
  output logic ready_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic ref_ovf_o
);
  localparam int unsigned PCW = cnt_bits(PAUSE_CYC);
  localparam int unsigned ICW = cnt_bits(INIT_CYCLES + 1);
  localparam logic [PCW-1:0] PAUSE_LAST = PCW'(PAUSE_CYC - 1);
  localparam logic [ICW-1:0] INIT_LD    = ICW'(INIT_CYCLES);

  phase_t         phase;
  logic [PCW-1:0] pause_cnt;
  logic [ICW-1:0] init_left;
  logic           host_own;

  // Named internal events (also observed by the checker).
  logic pause_active, run_active, pause_end, init_start, init_fin;
  logic ref_start, grant_take, seq_start, seq_busy, seq_done, seq_act;
  logic ref_pending, owe_sat, idle_expire;

  assign pause_active = (phase == PH_PAUSE);
  assign run_active   = (phase == PH_RUN);
  assign pause_end    = pause_active && (pause_cnt == PAUSE_LAST);
  assign init_start   = (phase == PH_INIT) && !seq_busy && (init_left != '0);
  assign init_fin     = (phase == PH_INIT) && !seq_busy && (init_left == '0);
  assign ref_start    = run_active && !seq_busy && !host_own && ref_pending;
  assign grant_take   = run_active && !seq_busy && !host_own && !ref_pending
                        && host_req_i && !idle_expire;
  assign seq_start    = init_start || ref_start;

  dref_strobe_seq #(
    .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(seq_start),
    .busy_o(seq_busy), .done_o(seq_done), .act_o(seq_act),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o)
  );

  dref_pace_timer #(
    .REF_PERIOD(REF_PERIOD), .OWE_MAX(OWE_MAX)
  ) u_pace (
    .clk(clk), .rst_n(rst_n), .en_i(run_active), .consume_i(ref_start),
    .pending_o(ref_pending), .sat_o(owe_sat), .ovf_o(ref_ovf_o)
  );

  dref_idle_watch #(
    .IDLE_LIMIT(IDLE_LIMIT)
  ) u_idle (
    .clk(clk), .rst_n(rst_n), .en_i(run_active),
    .act_i(seq_act || host_ras_i), .expire_o(idle_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_PAUSE;
      pause_cnt <= '0;
      init_left <= '0;
    end else begin
      case (phase)
        PH_PAUSE: begin
          if (pause_end) begin
            phase     <= PH_INIT;
            init_left <= INIT_LD;
          end else pause_cnt <= pause_cnt + PCW'(1);
        end
        PH_INIT: begin
          if (seq_done && init_left != '0) init_left <= init_left - ICW'(1);
          if (init_fin) phase <= PH_RUN;
        end
        PH_RUN: begin
          if (idle_expire) begin
            phase     <= PH_INIT;
            init_left <= INIT_LD;
          end
        end
        default: phase <= PH_PAUSE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_active || idle_expire) host_own <= 1'b0;
    else if (host_own && !host_req_i)         host_own <= 1'b0;
    else if (grant_take)                      host_own <= 1'b1;
  end

  assign host_gnt_o = host_own;
  assign ready_o    = run_active;

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int unsigned T_RAS = 5,
  parameter int unsigned T_RP  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic gnt,
  input logic ready,
  input logic ovf,
  input logic in_pause,
  input logic owe_sat
);
  logic [15:0] low_len, high_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_len  <= '0;
      high_len <= '1;
    end else begin
      low_len  <= ras_n ? '0 : ((low_len == '1) ? low_len : low_len + 16'd1);
      high_len <= !ras_n ? '0 : ((high_len == '1) ? high_len : high_len + 16'd1);
    end
  end

  a_r2_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
    in_pause |-> (ras_n && cas_n && !ready));

  a_r4_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));

  a_r4_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_len >= 16'(T_RAS)));

  a_r5_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (high_len >= 16'(T_RP)));

  a_r7_quiet_granted: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> (ras_n && cas_n));

  a_r3_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> ready);

  a_r9_ovf_sat: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> owe_sat);

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.T_RAS(T_RAS), .T_RP(T_RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n_o), .cas_n(cas_n_o), .gnt(host_gnt_o),
  .ready(ready_o), .ovf(ref_ovf_o), .in_pause(pause_active), .owe_sat(owe_sat)
);

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
  localparam int unsigned PAUSE = 40;
  localparam int unsigned INITN = 8;
  localparam int unsigned PER   = 60;
  localparam int unsigned IDLE  = 300;
  localparam int unsigned OMAX  = 3;
  localparam int unsigned TCSR  = 1;
  localparam int unsigned TCHR  = 2;
  localparam int unsigned TRAS  = 5;
  localparam int unsigned TRP   = 3;

  typedef struct packed {
    logic [7:0] k;          // grant held for about k periods
    logic [7:0] exp_falls;  // RAS falls within 45 cycles of release
    logic       exp_ovf;
  } vec_t;

  // k-1 refreshes fall due during the hold (saturating at OMAX), plus one paced tick in the window
  localparam vec_t VEC [5] = '{
    '{8'd1, 8'd1, 1'b0}, '{8'd2, 8'd2, 1'b0}, '{8'd3, 8'd3, 1'b0},
    '{8'd5, 8'd4, 1'b1}, '{8'd6, 8'd4, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, host_req = 1'b0, host_ras = 1'b0;
  logic gnt, ready, ras_n, cas_n, ovf;

  always #5 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INIT_CYCLES(INITN), .REF_PERIOD(PER), .IDLE_LIMIT(IDLE),
    .OWE_MAX(OMAX), .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req_i(host_req), .host_ras_i(host_ras),
    .host_gnt_o(gnt), .ready_o(ready), .ras_n_o(ras_n), .cas_n_o(cas_n), .ref_ovf_o(ovf)
  );

  int checks = 0, errors = 0;
  int falls = 0, shape_err = 0, prech_err = 0, gstrobe_err = 0, ovf_cnt = 0;
  int cas_low_len = 0, ras_low_len = 0, ras_high_len = 1000;
  logic prev_ras = 1'b1, prev_cas = 1'b1;

  // Strobe monitor (R4, R5, R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !ras_n) begin
        falls++;
        if (cas_low_len < int'(TCSR)) shape_err++;
        if (ras_high_len < int'(TRP)) prech_err++;
      end
      if (!prev_ras && ras_n && ras_low_len < int'(TRAS)) shape_err++;
      if (!prev_cas && cas_n && !ras_n && ras_low_len < int'(TCHR)) shape_err++;
      if (gnt && (!ras_n || !cas_n)) gstrobe_err++;
      if (ovf) ovf_cnt++;
      cas_low_len  = cas_n ? 0 : cas_low_len + 1;
      ras_low_len  = ras_n ? 0 : ras_low_len + 1;
      ras_high_len = ras_n ? ras_high_len + 1 : 0;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ras_rise();
    for (int i = 0; i < 400; i++) begin
      logic p;
      p = ras_n;
      tick();
      if (!p && ras_n) break;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int quiet, gate_err, f0, o0, cyc, first;
    repeat (3) tick();
    // R1 reset state
    chk(ras_n == 1'b1, "R1 ras_n", ras_n, 1);
    chk(cas_n == 1'b1, "R1 cas_n", cas_n, 1);
    chk(ready == 1'b0, "R1 ready", ready, 0);
    chk(gnt == 1'b0, "R1 gnt", gnt, 0);
    chk(ovf == 1'b0, "R1 ovf", ovf, 0);
    rst_n = 1'b1;

    // R2 pause
    quiet = 0;
    repeat (PAUSE) begin
      tick();
      if (!ras_n || !cas_n || ready) quiet++;
    end
    chk(quiet == 0, "R2 activity during pause", quiet, 0);

    // R3 init burst, requests held off
    host_req = 1'b1;
    gate_err = 0;
    for (int i = 0; i < 400 && !ready; i++) begin
      tick();
      if (gnt) gate_err++;
    end
    chk(ready == 1'b1, "R3 ready after init", ready, 1);
    chk(falls == int'(INITN), "R3 init pulse count", falls, INITN);
    chk(gate_err == 0, "R3 grant before ready", gate_err, 0);

    // R7 grant and release
    tick();
    chk(gnt == 1'b1, "R7 grant next cycle", gnt, 1);
    host_req = 1'b0;
    tick();
    chk(gnt == 1'b0, "R7 release next cycle", gnt, 0);

    // R6 pacing
    repeat (2 * PER) tick();
    f0 = falls;
    repeat (10 * PER) tick();
    chk(falls - f0 == 10, "R6 refreshes in 10 periods", falls - f0, 10);

    // R8/R9 table: grant held across k periods
    for (int v = 0; v < 5; v++) begin
      repeat (2 * PER) tick();
      wait_ras_rise();
      o0 = ovf_cnt;
      host_req = 1'b1;
      host_ras = 1'b1;
      for (int i = 0; i < 50 && !gnt; i++) tick();
      chk(gnt == 1'b1, "R7 table grant", gnt, 1);
      repeat (int'(VEC[v].k) * int'(PER) - 30) tick();
      host_req = 1'b0;
      host_ras = 1'b0;
      f0 = falls;
      tick();
      chk(gnt == 1'b0, "R7 table release", gnt, 0);
      repeat (44) tick();
      chk(falls - f0 == int'(VEC[v].exp_falls), "R8 owed refreshes", falls - f0,
          int'(VEC[v].exp_falls));
      chk((ovf_cnt != o0) == VEC[v].exp_ovf, "R9 overflow pulse", ovf_cnt - o0,
          int'(VEC[v].exp_ovf));
    end

    // R10 re-init after idle grant
    repeat (2 * PER) tick();
    wait_ras_rise();
    host_req = 1'b1;
    host_ras = 1'b0;
    cyc = 0;
    while (cyc < int'(IDLE + 3 * PER) && ready) begin
      tick();
      cyc++;
    end
    chk(ready == 1'b0, "R10 ready dropped", ready, 0);
    chk(gnt == 1'b0, "R10 grant revoked", gnt, 0);
    chk(cyc >= int'(IDLE) - 5 && cyc <= int'(IDLE) + 5, "R10 idle limit", cyc, IDLE);
    host_req = 1'b0;
    f0 = falls;
    first = -1;
    for (int i = 0; i < 400 && !ready; i++) begin
      tick();
      if (falls > f0 && first < 0) first = i;
    end
    chk(first >= 0 && first < 10, "R10 no pause before burst", first, 1);
    chk(ready == 1'b1 && falls - f0 == int'(INITN), "R10 re-init pulses", falls - f0, INITN);

    // Whole-run strobe shape
    chk(shape_err == 0, "R4 CBR shape violations", shape_err, 0);
    chk(prech_err == 0, "R5 precharge violations", prech_err, 0);
    chk(gstrobe_err == 0, "R7 strobe while granted", gstrobe_err, 0);
    finish_run();
  end

endmodule